// File: doc/BRIEF.md
# Configurable Error/Warning Aggregator

This block collects the fault and warning events raised inside a sensor interface chip and turns them into two active-low summary flags, one for errors and one for warnings, that a serial interface sends to a host. Each internal event is caught in a sticky status register, so a single-cycle pulse is never missed. A host read of the status register returns the caught bits and clears them. The only exception is the configuration-memory fault, which a soft-reset command alone removes.

Which messages reach the flags is decided in three ways. Some messages always reach the error flag. Others reach it only while a protocol, multiturn or synchronization mode is selected. The rest pass through an 8-bit enable mask whose bits are active low. An external fault, sensed on a shared open-drain pin, may be routed to the error flag. It is never stored. The block pulls that shared pin low whenever its own error flag is active, and also on a nonius counter error. An enabled over-temperature error raises a safe-mode request for the analog logic downstream.

Top module: `fault_aggregator`

## Requirements
- R1: Both flags are active low. With no enabled source present, `err_n` and `wrn_n` are 1 and `fault_drive` and `safe_mode` are 0, which is also their state after reset.
- R2: The status layout is: bit 0 memory fault, 1 memory absent, 2 command-conversion fault, 3 CRC fault, 4 register fault, 5 multiturn error, 6 multiturn counter, 7 nonius counter, 8 startup frequency, 9 over-temperature error, 10 frequency warning, 11 temperature warning, 12 multiturn warning, then NCH amplitude-high bits, NCH amplitude-low bits, NCH amplitude-control-high bits and NCH amplitude-control-low bits. A 1 on `evt_in[i]` at a clock edge sets `status[i]` from that edge on. The bit stays set until it is cleared.
- R3: A `rd_clr` pulse at an edge clears every status bit except bit 0. An event present at that same edge is still set after it.
- R4: Status bit 0 is cleared only by `soft_rst`. `rd_clr` leaves it set.
- R5: Mask bits are enabled at 0. Bit 7 routes any amplitude high or low bit to the error flag, bit 6 routes the external fault and bit 5 routes the over-temperature error.
- R6: Mask bits 4, 3, 2, 1 and 0 route, in that order, the frequency warning, the amplitude high/low bits, the amplitude-control high/low bits, the temperature warning and the multiturn warning to the warning flag.
- R7: Status bits 0, 2 and 3 always activate the error flag. Bit 2 also always activates the warning flag. Bit 1 activates neither flag.
- R8: Bit 4 activates the error flag only when `proto_sel` is 1. Bits 5 and 6 do so only when `mt_mode` is 01 or 10. Bits 7 and 8 do so only when `sync_nonius` is 1.
- R9: `ext_fault_n` is active low. It passes through two synchronizing flops, so a change shows on `err_n` after the second clock edge. It is never stored in the status register and never affects `wrn_n`.
- R10: `fault_drive` is 1 whenever the error flag is active. It is also 1 whenever status bit 7 is set, whatever the mask and the modes.
- R11: `safe_mode` is 1 exactly when status bit 9 is set and mask bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 13+4*NCH | Event pulses, in the status layout |
| cfg_mask | input | 8 | Enable mask, 0 enables |
| proto_sel | input | 1 | Serial protocol select gating the register fault |
| mt_mode | input | 2 | Multiturn mode |
| sync_nonius | input | 1 | Nonius synchronization selected |
| rd_clr | input | 1 | Status read strobe, clears readable bits |
| soft_rst | input | 1 | Soft-reset command, clears the memory fault |
| ext_fault_n | input | 1 | Level sensed on the shared fault pin, active low |
| status | output | 13+4*NCH | Sticky status register |
| err_n | output | 1 | Error flag, active low |
| wrn_n | output | 1 | Warning flag, active low |
| fault_drive | output | 1 | 1 pulls the shared open-drain pin low |
| safe_mode | output | 1 | Safe-mode request |

## Verification
The hardest case is one where the flag outputs depend on the combination of the mask, the three mode inputs and which single event was caught. A fault that is blocked in one setting must be seen to stay silent at the ports in every other setting too. The bench clears the register, fires exactly one event and waits one idle cycle, so that stickiness is also tested. It repeats this for every event bit against all 256 mask values. The mode inputs are taken from the low mask bits, so every mode combination meets every event. The timing of the external input, the read-clear race and the soft-reset-only bit are driven by directed sequences.

// File: rtl/fault_agg_pkg.sv
package fault_agg_pkg;
    localparam int IDX_MEM    = 0;
    localparam int IDX_ABSENT = 1;
    localparam int IDX_CMD    = 2;
    localparam int IDX_CRC    = 3;
    localparam int IDX_REG    = 4;
    localparam int IDX_MTERR  = 5;
    localparam int IDX_MTCNT  = 6;
    localparam int IDX_NON    = 7;
    localparam int IDX_STUP   = 8;
    localparam int IDX_TERR   = 9;
    localparam int IDX_FWRN   = 10;
    localparam int IDX_TWRN   = 11;
    localparam int IDX_MTWRN  = 12;
    localparam int FIXED_BITS = 13;

    localparam int MB_AMP_ERR  = 7;
    localparam int MB_EXT_ERR  = 6;
    localparam int MB_TEMP_ERR = 5;
    localparam int MB_FREQ_WRN = 4;
    localparam int MB_AMP_WRN  = 3;
    localparam int MB_ACTL_WRN = 2;
    localparam int MB_TEMP_WRN = 1;
    localparam int MB_MT_WRN   = 0;

    function automatic int status_width(input int nch);
        return FIXED_BITS + 4 * nch;
    endfunction
endpackage

// File: rtl/fault_sync2.sv
module fault_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_n;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = ~st_q.s2;
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
    parameter int SW      = 25,
    parameter int KEEP_IX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] evt,
    input  logic          rd_clr,
    input  logic          soft_rst,
    output logic [SW-1:0] bits
);
    typedef struct packed {
        logic [SW-1:0] bits;
    } sreg_t;

    sreg_t st_d, st_q;
    logic [SW-1:0] clr_vec;

    for (genvar g = 0; g < SW; g++) begin : g_clr
        if (g == KEEP_IX) begin : g_keep
            assign clr_vec[g] = soft_rst;
        end else begin : g_norm
            assign clr_vec[g] = rd_clr;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = evt | (st_q.bits & ~clr_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;
endmodule

// File: rtl/fault_router.sv
module fault_router
    import fault_agg_pkg::*;
#(
    parameter int NCH = 3,
    localparam int SW = FIXED_BITS + 4 * NCH
) (
    input  logic [SW-1:0] sts,
    input  logic [7:0]    mask,
    input  logic          proto_sel,
    input  logic [1:0]    mt_mode,
    input  logic          sync_nonius,
    input  logic          ext_act,
    output logic          err_act,
    output logic          wrn_act,
    output logic          pin_act,
    output logic          safe_act
);
    localparam int AHI = FIXED_BITS;
    localparam int ALO = FIXED_BITS + NCH;
    localparam int CHI = FIXED_BITS + 2 * NCH;
    localparam int CLO = FIXED_BITS + 3 * NCH;

    logic [NCH-1:0] amp_ch, actl_ch;
    logic amp_any, actl_any;
    logic fixed_err, gated_err, masked_err;
    logic mt_on;
    logic [7:0] en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign amp_ch[c]  = sts[AHI + c] | sts[ALO + c];
        assign actl_ch[c] = sts[CHI + c] | sts[CLO + c];
    end

    always_comb begin
        en        = ~mask;
        amp_any   = |amp_ch;
        actl_any  = |actl_ch;
        mt_on     = (mt_mode == 2'b01) || (mt_mode == 2'b10);

        fixed_err = sts[IDX_MEM] | sts[IDX_CMD] | sts[IDX_CRC];
        gated_err = (sts[IDX_REG] & proto_sel)
                  | ((sts[IDX_MTERR] | sts[IDX_MTCNT]) & mt_on)
                  | ((sts[IDX_NON] | sts[IDX_STUP]) & sync_nonius);
        masked_err = (amp_any & en[MB_AMP_ERR])
                   | (ext_act & en[MB_EXT_ERR])
                   | (sts[IDX_TERR] & en[MB_TEMP_ERR]);

        err_act  = fixed_err | gated_err | masked_err;
        wrn_act  = sts[IDX_CMD]
                 | (sts[IDX_FWRN]  & en[MB_FREQ_WRN])
                 | (amp_any        & en[MB_AMP_WRN])
                 | (actl_any       & en[MB_ACTL_WRN])
                 | (sts[IDX_TWRN]  & en[MB_TEMP_WRN])
                 | (sts[IDX_MTWRN] & en[MB_MT_WRN]);
        pin_act  = err_act | sts[IDX_NON];
        safe_act = sts[IDX_TERR] & en[MB_TEMP_ERR];
    end
endmodule

// File: rtl/fault_aggregator.sv
module fault_aggregator
    import fault_agg_pkg::*;
#(
    parameter int NCH = 3,
    localparam int SW = FIXED_BITS + 4 * NCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] evt_in,
    input  logic [7:0]    cfg_mask,
    input  logic          proto_sel,
    input  logic [1:0]    mt_mode,
    input  logic          sync_nonius,
    input  logic          rd_clr,
    input  logic          soft_rst,
    input  logic          ext_fault_n,
    output logic [SW-1:0] status,
    output logic          err_n,
    output logic          wrn_n,
    output logic          fault_drive,
    output logic          safe_mode
);
    logic ext_act;
    logic err_act, wrn_act, pin_act, safe_act;

    fault_sync2 u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (ext_fault_n),
        .active (ext_act)
    );

    fault_status_reg #(
        .SW      (SW),
        .KEEP_IX (IDX_MEM)
    ) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_in),
        .rd_clr   (rd_clr),
        .soft_rst (soft_rst),
        .bits     (status)
    );

    fault_router #(.NCH(NCH)) u_route (
        .sts         (status),
        .mask        (cfg_mask),
        .proto_sel   (proto_sel),
        .mt_mode     (mt_mode),
        .sync_nonius (sync_nonius),
        .ext_act     (ext_act),
        .err_act     (err_act),
        .wrn_act     (wrn_act),
        .pin_act     (pin_act),
        .safe_act    (safe_act)
    );

    assign err_n       = ~err_act;
    assign wrn_n       = ~wrn_act;
    assign fault_drive = pin_act;
    assign safe_mode   = safe_act;
endmodule

// File: rtl/fault_aggregator_chk.sv
module fault_aggregator_chk
    import fault_agg_pkg::*;
#(
    parameter int NCH = 3,
    localparam int SW = FIXED_BITS + 4 * NCH
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] evt_in,
    input logic          rd_clr,
    input logic          soft_rst,
    input logic [SW-1:0] status,
    input logic          err_n,
    input logic          wrn_n,
    input logic          fault_drive,
    input logic          safe_mode
);
    p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status & $past(evt_in)) == $past(evt_in)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_clr) && !$past(soft_rst))
        |-> ((status & $past(status)) == $past(status)));

    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_clr))
        |-> (status[SW-1:1] == $past(evt_in[SW-1:1])));

    p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(status[IDX_MEM]) && !$past(soft_rst))
        |-> status[IDX_MEM]);

    p_cmd_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[IDX_CMD] |-> (!err_n && !wrn_n));

    p_pin_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n || status[IDX_NON]) |-> fault_drive);

    p_safe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        safe_mode |-> (status[IDX_TERR] && !err_n));
endmodule

bind fault_aggregator fault_aggregator_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_in      (evt_in),
    .rd_clr      (rd_clr),
    .soft_rst    (soft_rst),
    .status      (status),
    .err_n       (err_n),
    .wrn_n       (wrn_n),
    .fault_drive (fault_drive),
    .safe_mode   (safe_mode)
);

// File: tb/fault_aggregator_tb.sv
`timescale 1ns/1ps
module fault_aggregator_tb;
    localparam int NCH = 3;
    localparam int SW  = 13 + 4 * NCH;
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] evt_in = '0;
    logic [7:0]    cfg_mask = 8'hFF;
    logic          proto_sel = 1'b0;
    logic [1:0]    mt_mode = 2'b00;
    logic          sync_nonius = 1'b0;
    logic          rd_clr = 1'b0;
    logic          soft_rst = 1'b0;
    logic          ext_fault_n = 1'b1;
    logic [SW-1:0] status;
    logic          err_n, wrn_n, fault_drive, safe_mode;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fault_aggregator #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_mask(cfg_mask),
        .proto_sel(proto_sel), .mt_mode(mt_mode), .sync_nonius(sync_nonius),
        .rd_clr(rd_clr), .soft_rst(soft_rst), .ext_fault_n(ext_fault_n),
        .status(status), .err_n(err_n), .wrn_n(wrn_n),
        .fault_drive(fault_drive), .safe_mode(safe_mode)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input int i, input logic [7:0] m,
                                         input bit pr, input logic [1:0] mt,
                                         input bit sy);
        bit amp, actl, e, w;
        amp  = (i >= 13) && (i < 13 + 2 * NCH);
        actl = (i >= 13 + 2 * NCH) && (i < SW);
        e = (i == 0) || (i == 2) || (i == 3)
          || (i == 4 && pr)
          || ((i == 5 || i == 6) && (mt == 2'b01 || mt == 2'b10))
          || ((i == 7 || i == 8) && sy)
          || (amp && !m[7]) || (i == 9 && !m[5]);
        w = (i == 2) || (i == 10 && !m[4]) || (amp && !m[3])
          || (actl && !m[2]) || (i == 11 && !m[1]) || (i == 12 && !m[0]);
        return {!e, !w, e || (i == 7), (i == 9) && !m[5]};
    endfunction

    task automatic wipe();
        evt_in = '0; rd_clr = 1'b1; soft_rst = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] got, exp;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(status == '0 && err_n && wrn_n && !fault_drive && !safe_mode,
              "R1 reset", {status, err_n, wrn_n, fault_drive, safe_mode},
              {{SW{1'b0}}, 4'b1100});
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R5 R6 R7 R8 R10 R11: one event per vector, all masks
        for (int i = 0; i < SW; i++) begin
            for (int m = 0; m < 256; m++) begin
                cfg_mask = m[7:0];
                proto_sel = m[0]; mt_mode = m[2:1]; sync_nonius = m[3];
                wipe();
                evt_in = '0; evt_in[i] = 1'b1;
                @(negedge clk);
                evt_in = '0;
                @(negedge clk);
                got = {err_n, wrn_n, fault_drive, safe_mode};
                exp = model(i, m[7:0], m[0], m[2:1], m[3]);
                check(status == (SW'(1) << i) && got == exp,
                      $sformatf("R2/R5/R6/R7/R8/R10/R11 bit%0d mask%0h", i, m),
                      {status, got}, {(SW'(1) << i), exp});
            end
        end

        // R3: read clear races a new event; bit 0 survives
        cfg_mask = 8'hFF; proto_sel = 0; mt_mode = 0; sync_nonius = 0;
        wipe();
        evt_in = '0; evt_in[0] = 1'b1; evt_in[5] = 1'b1;
        @(negedge clk);
        evt_in = '0; evt_in[3] = 1'b1; rd_clr = 1'b1;
        @(negedge clk);
        evt_in = '0; rd_clr = 1'b0;
        check(status == SW'('b1001), "R3 clear with racing event",
              status, SW'('b1001));
        // R4: second read leaves bit 0
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        check(status == SW'(1), "R4 read keeps memory fault", status, SW'(1));
        check(!err_n, "R7 memory fault holds error flag", err_n, 0);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(status == '0 && err_n, "R4 soft reset clears",
              {status, err_n}, {{SW{1'b0}}, 1'b1});

        // R9: external fault timing, no latching, never warning
        for (int m = 0; m < 256; m++) begin
            cfg_mask = m[7:0];
            ext_fault_n = 1'b0;
            @(negedge clk);
            check(err_n == 1'b1, "R9 ext one edge", err_n, 1);
            @(negedge clk);
            check(err_n == m[6] && wrn_n == 1'b1 && fault_drive == !m[6],
                  "R9 ext two edges", {err_n, wrn_n, fault_drive},
                  {m[6], 1'b1, !m[6]});
            ext_fault_n = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check(err_n == 1'b1 && status == '0, "R9 ext not stored",
                  {status, err_n}, {{SW{1'b0}}, 1'b1});
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule